// File: doc/BRIEF.md
# SPI Burst Master

This block is a register-programmed SPI master. Software sets up the serial format through a control register and queues 32-bit words into a four-word transmit queue. It then sets an exchange bit. The block sends every queued word as a word of 1 to 32 bits, most significant bit first. For each word it captures the bits that come back and places the result, right-aligned, into a four-word receive queue.

When the transmit queue runs dry and the last word has finished, the block clears the exchange bit, releases the chip-select line and sets a transfer-complete flag. The flag stays set until software writes a one to it. The serial clock polarity and sampling phase can be chosen. One of four select lines is driven, with a programmable active level. The serial clock runs at the system clock divided by four times a power of two.

The register bus uses word addresses: 0 reads the receive queue, 1 writes the transmit queue, 2 is the control register and 3 is the status register. A read or write strobe is high for one clock per access. Read data is valid combinationally while the read strobe is high, and the access takes effect at the clock edge.

Top module: `spi_burst_master`

## Requirements
- R1: After reset, control (address 2) and status (address 3) read zero, all four select lines are high and the serial clock is low.
- R2: Control bits [12:8] hold N-1 for an N-bit word. The bits of a word leave MSB first, starting from bit N-1 of the queued word, and transmit bits above N-1 are ignored. The received N bits land right-aligned with zeros above them, and each word takes exactly 2N serial clock edges.
- R3: Control bit 4 gives the idle level of the serial clock. With control bit 5 clear, data is valid before the leading edge and is sampled on it. With bit 5 set, data changes on the leading edge and is sampled on the trailing edge.
- R4: For control bits [18:16] = n, each serial clock half period lasts 2<<n system clocks, so the full period is 4<<n clocks.
- R5: Control bits [25:24] choose one of four select lines, and control bit 7 set makes that line active-high. Only the chosen line is active, for the whole exchange. All other lines, and all lines outside an exchange, sit at the inactive level.
- R6: Setting control bit 2 while bits 0 (enable) and 1 (master) are set starts an exchange. Once the transmit queue is drained and the last word is done, status bit 8 sets, control bit 2 reads back zero and the select line is released. Writing 1 to status bit 8 clears it.
- R7: Each write to address 1 queues one word in a four-deep transmit queue. A write while the queue is full is ignored.
- R8: The receive queue is four deep. A word that completes while it is full is dropped, and status bit 6 is set. Writing 1 to status bit 6 clears it.
- R9: A read of address 0 returns and removes the oldest received word. A read of an empty receive queue returns zero.
- R10: Clearing control bit 0 empties both queues and stops the shifter.
- R11: Starting an exchange with an empty transmit queue completes it with no serial clock edge.
- R12: A word written to address 1 while an exchange is running, before its last word ends, is sent within the same exchange.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rd |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_line | output | 4 | Chip-select lines |

## Verification
A software write to the transmit queue can land in the same clock cycle in which the shifter pops its only queued word. When that happens the queue must keep the new word, and the exchange must not end early. The bench provokes this by queueing one word, setting the exchange bit, and then writing a second word with its delay swept across several cycles around the moment of the pop. Each case is judged by the serial words seen on the wire, the edge count of two full words, and two matching words read back from the receive queue.

// File: rtl/spi_burst_pkg.sv
// Package: shared register layout and engine state type for the SPI burst master.
// Assumes a 32-bit register bus with word addresses.
package spi_burst_pkg;
    localparam int REG_W    = 32;
    localparam int ADDR_W   = 2;
    localparam int LEN_W    = 5;   // burst length field width (bits minus one)
    localparam int RATE_W   = 3;   // divider code width
    localparam int CSEL_W   = 2;   // select field width
    localparam int CS_N     = 1 << CSEL_W;

    localparam logic [ADDR_W-1:0] A_RXQ  = 2'd0;
    localparam logic [ADDR_W-1:0] A_TXQ  = 2'd1;
    localparam logic [ADDR_W-1:0] A_CTRL = 2'd2;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd3;

    localparam int C_EN     = 0;
    localparam int C_MASTER = 1;
    localparam int C_XCH    = 2;
    localparam int C_POL    = 4;
    localparam int C_PHA    = 5;
    localparam int C_CSHI   = 7;
    localparam int C_LEN    = 8;
    localparam int C_RATE   = 16;
    localparam int C_CSEL   = 24;

    localparam int S_OVF    = 6;
    localparam int S_DONE   = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SHIFT,
        ST_STORE,
        ST_FINISH
    } eng_state_t;
endpackage

// File: rtl/spi_word_fifo.sv
// Module: synchronous word queue with show-ahead read data.
// Assumes pop is only honoured when not empty; a push while full is honoured
// only if a pop happens in the same cycle; clr empties the queue.
module spi_word_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic          full,
    output logic          empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign rdata   = mem[rd_ptr];

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_next(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
            count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    a_r7_full_push_ignored: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (full && push && !pop) |=> (count == CNT_W'(DEPTH)));
endmodule

// File: rtl/spi_rate_gen.sv
// Module: half-period tick generator for the serial clock.
// Assumes run is held high for the whole shift phase; the tick repeats every
// 2<<rate system clocks counted from the cycle run rises.
module spi_rate_gen #(
    parameter int RATE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    localparam int MAX_HALF = 2 << ((1 << RATE_W) - 1);
    localparam int CNT_W    = $clog2(MAX_HALF);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   half_m1;

    assign half_m1 = ((CNT_W+1)'(2) << rate) - (CNT_W+1)'(1);
    assign tick    = run && ({1'b0, cnt} == half_m1);

    // Count system clocks within one half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)  cnt <= '0;
        else if (tick)       cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

    a_r4_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && run) |=> !tick);
endmodule

// File: rtl/spi_shift_engine.sv
// Module: serial shifter for one exchange of queued words.
// Assumes configuration is stable while an exchange runs; clr aborts
// everything. Each word: load, 2N serial edges, store, then next word or finish.
module spi_shift_engine
    import spi_burst_pkg::*;
#(
    parameter int DW     = 32,
    parameter int LW     = $clog2(DW),
    parameter int RW     = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          start,
    input  logic          pol,
    input  logic          pha,
    input  logic [LW-1:0] last_bit,
    input  logic [RW-1:0] rate,
    input  logic          tx_empty,
    input  logic [DW-1:0] tx_word,
    output logic          tx_pop,
    output logic          rx_push,
    output logic [DW-1:0] rx_word,
    output logic          done,
    output logic          cs_act,
    output logic          sclk,
    output logic          mosi,
    input  logic          miso
);
    localparam int EDGE_W = LW + 1;

    eng_state_t        state;
    logic [DW-1:0]     sh, rx_sh, aligned;
    logic [EDGE_W-1:0] edge_cnt, last_edge;
    logic              sclk_r, mosi_r, cs_r, tick;
    logic              leading, sample, shift_out;

    spi_rate_gen #(.RATE_W(RW)) u_rate (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (state == ST_SHIFT),
        .rate (rate),
        .tick (tick)
    );

    assign last_edge = {last_bit, 1'b1};
    assign aligned   = tx_word << (LW'(DW - 1) - last_bit);
    assign leading   = !edge_cnt[0];
    assign sample    = leading ^ pha;
    assign shift_out = pha ? leading : (!leading && (edge_cnt != last_edge));

    // Sequence load, shift, store and finish for every queued word.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            state    <= ST_IDLE;
            sh       <= '0;
            rx_sh    <= '0;
            edge_cnt <= '0;
            sclk_r   <= 1'b0;
            mosi_r   <= 1'b0;
            cs_r     <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) state <= tx_empty ? ST_FINISH : ST_LOAD;
                end
                ST_LOAD: begin
                    if (!pha) begin
                        mosi_r <= aligned[DW-1];
                        sh     <= aligned << 1;
                    end else begin
                        sh     <= aligned;
                    end
                    rx_sh    <= '0;
                    edge_cnt <= '0;
                    sclk_r   <= 1'b0;
                    cs_r     <= 1'b1;
                    state    <= ST_SHIFT;
                end
                ST_SHIFT: begin
                    if (tick) begin
                        sclk_r   <= ~sclk_r;
                        edge_cnt <= edge_cnt + 1'b1;
                        if (sample) rx_sh <= {rx_sh[DW-2:0], miso};
                        if (shift_out) begin
                            mosi_r <= sh[DW-1];
                            sh     <= sh << 1;
                        end
                        if (edge_cnt == last_edge) state <= ST_STORE;
                    end
                end
                ST_STORE: begin
                    state <= tx_empty ? ST_FINISH : ST_LOAD;
                end
                ST_FINISH: begin
                    cs_r  <= 1'b0;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign tx_pop  = (state == ST_LOAD);
    assign rx_push = (state == ST_STORE);
    assign rx_word = rx_sh;
    assign done    = (state == ST_FINISH);
    assign cs_act  = cs_r;
    assign sclk    = sclk_r ^ pol;
    assign mosi    = mosi_r;

    a_r5_cs_held_while_shifting: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (state == ST_SHIFT) |-> cs_r);
    a_r6_done_releases_cs: assert property (@(posedge clk) disable iff (!rst_n || clr)
        done |=> !cs_r);
    a_r3_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (sclk == pol));
    a_r11_empty_start: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (state == ST_IDLE && start && tx_empty) |=> (state == ST_FINISH));
    a_r2_edge_bound: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (state == ST_SHIFT) |-> (edge_cnt <= last_edge));
endmodule

// File: rtl/spi_burst_master.sv
// Module: top of the SPI burst master: register file, both queues, shifter
// and select-line decode. Assumes one-cycle bus strobes and word addresses.
module spi_burst_master
    import spi_burst_pkg::*;
#(
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [CS_N-1:0]   cs_line
);
    logic              en, master, xch, pol, pha, cs_high;
    logic [LEN_W-1:0]  last_bit;
    logic [RATE_W-1:0] rate;
    logic [CSEL_W-1:0] csel;
    logic              st_done, st_ovf;

    logic              wr_ctrl, wr_stat, wr_tx, rd_rx;
    logic              tx_pop, tx_full, tx_empty;
    logic [REG_W-1:0]  tx_head;
    logic              rx_push, rx_full, rx_empty;
    logic [REG_W-1:0]  rx_word, rx_head;
    logic              eng_done, cs_act, rx_drop;
    logic [REG_W-1:0]  ctrl_rd, stat_rd;

    assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
    assign wr_stat = bus_wr && (bus_addr == A_STAT);
    assign wr_tx   = bus_wr && (bus_addr == A_TXQ);
    assign rd_rx   = bus_rd && (bus_addr == A_RXQ);
    assign rx_drop = rx_push && rx_full && !rd_rx;

    // Control register: software fields, exchange bit cleared on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en <= 1'b0; master <= 1'b0; xch <= 1'b0;
            pol <= 1'b0; pha <= 1'b0; cs_high <= 1'b0;
            last_bit <= '0; rate <= '0; csel <= '0;
        end else begin
            if (wr_ctrl) begin
                en       <= bus_wdata[C_EN];
                master   <= bus_wdata[C_MASTER];
                xch      <= bus_wdata[C_XCH];
                pol      <= bus_wdata[C_POL];
                pha      <= bus_wdata[C_PHA];
                cs_high  <= bus_wdata[C_CSHI];
                last_bit <= bus_wdata[C_LEN +: LEN_W];
                rate     <= bus_wdata[C_RATE +: RATE_W];
                csel     <= bus_wdata[C_CSEL +: CSEL_W];
            end
            if (eng_done) xch <= 1'b0;
        end
    end

    // Status flags: set by events, cleared by writing one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_done <= 1'b0;
            st_ovf  <= 1'b0;
        end else begin
            st_done <= eng_done || (st_done && !(wr_stat && bus_wdata[S_DONE]));
            st_ovf  <= rx_drop  || (st_ovf  && !(wr_stat && bus_wdata[S_OVF]));
        end
    end

    spi_word_fifo #(.DW(REG_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(!en),
        .push(wr_tx), .wdata(bus_wdata),
        .pop(tx_pop), .rdata(tx_head),
        .full(tx_full), .empty(tx_empty)
    );

    spi_word_fifo #(.DW(REG_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(!en),
        .push(rx_push), .wdata(rx_word),
        .pop(rd_rx), .rdata(rx_head),
        .full(rx_full), .empty(rx_empty)
    );

    spi_shift_engine #(.DW(REG_W), .LW(LEN_W), .RW(RATE_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .clr(!en),
        .start(en && master && xch),
        .pol(pol), .pha(pha), .last_bit(last_bit), .rate(rate),
        .tx_empty(tx_empty), .tx_word(tx_head), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_word(rx_word),
        .done(eng_done), .cs_act(cs_act),
        .sclk(sclk), .mosi(mosi), .miso(miso)
    );

    // Select-line decode: chosen line at the active level during an exchange.
    for (genvar i = 0; i < CS_N; i++) begin : g_cs
        assign cs_line[i] = (cs_act && (csel == CSEL_W'(i))) ? cs_high : !cs_high;
    end

    // Register read assembly.
    always_comb begin
        ctrl_rd = '0;
        ctrl_rd[C_EN]                 = en;
        ctrl_rd[C_MASTER]             = master;
        ctrl_rd[C_XCH]                = xch;
        ctrl_rd[C_POL]                = pol;
        ctrl_rd[C_PHA]                = pha;
        ctrl_rd[C_CSHI]               = cs_high;
        ctrl_rd[C_LEN +: LEN_W]       = last_bit;
        ctrl_rd[C_RATE +: RATE_W]     = rate;
        ctrl_rd[C_CSEL +: CSEL_W]     = csel;
        stat_rd = '0;
        stat_rd[S_DONE]               = st_done;
        stat_rd[S_OVF]                = st_ovf;
    end

    // Read data multiplexer.
    always_comb begin
        case (bus_addr)
            A_RXQ:   bus_rdata = rx_empty ? '0 : rx_head;
            A_CTRL:  bus_rdata = ctrl_rd;
            A_STAT:  bus_rdata = stat_rd;
            default: bus_rdata = '0;
        endcase
    end

    a_r8_overflow_flag: assert property (@(posedge clk) disable iff (!rst_n)
        rx_drop |=> st_ovf);
    a_r6_done_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> (st_done && !xch));
    a_r5_single_select: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cs_line ^ {CS_N{!cs_high}}) <= 1);
endmodule

// File: tb/spi_burst_master_tb.sv
// Bench: scoreboard for the SPI burst master with a loopback slave
// (miso = mosi, optionally inverted). A wire monitor decodes serial words
// per mode and checks divider timing and select lines.
module spi_burst_master_tb;
    import spi_burst_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sclk, mosi, miso, inv = 1'b0;
    logic [3:0]  cs_line;

    always #4 clk = ~clk;
    assign miso = mosi ^ inv;

    spi_burst_master u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_line(cs_line)
    );

    int n_cmp = 0, n_bad = 0;
    logic [31:0] exp_rx_q[$];
    logic [31:0] exp_ser_q[$];
    logic [31:0] got_ser_q[$];

    logic        cur_pol = 0, cur_pha = 0, cur_cshigh = 0, mon_on = 0;
    int          cur_bits = 8, cur_rate = 0, cur_csel = 0;
    logic [31:0] cur_ctrl = '0;
    int          edges = 0, cs_errs = 0, div_errs = 0, mon_n = 0;
    longint      cyc = 0, lead_cyc = 0;
    logic [31:0] mon_sh = '0;
    logic        prev_sclk = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mask(input int bits);
        return (bits >= 32) ? 32'hFFFF_FFFF : ((32'h1 << bits) - 32'h1);
    endfunction

    function automatic logic [3:0] act_pattern();
        logic [3:0] p;
        for (int i = 0; i < 4; i++) p[i] = (i == cur_csel) ? cur_cshigh : !cur_cshigh;
        return p;
    endfunction

    // Wire monitor: decodes serial words, checks half-period and select lines.
    always @(negedge clk) begin
        logic leading;
        cyc++;
        if (mon_on && sclk !== prev_sclk) begin
            leading = (sclk != cur_pol);
            edges++;
            if (cs_line !== act_pattern()) cs_errs++;
            if (leading) lead_cyc = cyc;
            else if (cyc - lead_cyc != longint'(2 << cur_rate)) div_errs++;
            if (leading ^ cur_pha) begin
                mon_sh = {mon_sh[30:0], mosi};
                mon_n++;
                if (mon_n == cur_bits) begin
                    got_ser_q.push_back(mon_sh & mask(cur_bits));
                    mon_n = 0;
                    mon_sh = '0;
                end
            end
        end
        prev_sclk = sclk;
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic configure(input int bits, input logic pol, input logic pha,
                             input logic cshigh, input int rate, input int csel);
        cur_ctrl = 32'h3 | (32'(pol) << 4) | (32'(pha) << 5) | (32'(cshigh) << 7)
                 | (32'(bits - 1) << 8) | (32'(rate) << 16) | (32'(csel) << 24);
        wr(A_CTRL, cur_ctrl);
        cur_bits = bits; cur_pol = pol; cur_pha = pha;
        cur_cshigh = cshigh; cur_rate = rate; cur_csel = csel;
    endtask

    // Driver: queue a word and push the expected serial and received values.
    task automatic queue_word(input logic [31:0] w, input bit on_wire, input bit to_rx);
        wr(A_TXQ, w);
        if (on_wire) exp_ser_q.push_back(w & mask(cur_bits));
        if (to_rx)   exp_rx_q.push_back((w ^ {32{inv}}) & mask(cur_bits));
    endtask

    task automatic kick();
        edges = 0; cs_errs = 0; div_errs = 0; mon_n = 0; mon_sh = '0;
        mon_on = 1'b1;
        wr(A_CTRL, cur_ctrl | 32'h4);
    endtask

    task automatic wait_done(input string tag, input int nwords);
        logic [31:0] s;
        s = '0;
        for (int k = 0; k < 8000; k++) begin
            rd(A_STAT, s);
            if (s[S_DONE]) break;
        end
        mon_on = 1'b0;
        chk({tag, " R6 done flag"}, 32'(s[S_DONE]), 32'd1);
        rd(A_CTRL, s);
        chk({tag, " R6 xch self-clear"}, 32'(s[C_XCH]), 32'd0);
        chk({tag, " R2 edge count"}, edges, 2 * cur_bits * nwords);
        chk({tag, " R5 select during edges"}, cs_errs, 0);
        chk({tag, " R4 half period"}, div_errs, 0);
        chk({tag, " R5 select released"}, 32'(cs_line), cur_cshigh ? 32'h0 : 32'hF);
        wr(A_STAT, 32'h1 << S_DONE);
        rd(A_STAT, s);
        chk({tag, " R6 done cleared"}, 32'(s[S_DONE]), 32'd0);
    endtask

    // Scoreboard on the wire: compare decoded serial words with queued ones.
    task automatic compare_serial(input string tag);
        while (exp_ser_q.size() > 0) begin
            logic [31:0] e;
            e = exp_ser_q.pop_front();
            if (got_ser_q.size() == 0) chk({tag, " R3 serial word missing"}, 32'hDEAD_0000, e);
            else chk({tag, " R3 serial word"}, got_ser_q.pop_front(), e);
        end
        chk({tag, " R2 no extra serial word"}, got_ser_q.size(), 0);
        got_ser_q.delete();
    endtask

    task automatic drain_rx(input string tag);
        logic [31:0] d;
        while (exp_rx_q.size() > 0) begin
            rd(A_RXQ, d);
            chk({tag, " R2 received word"}, d, exp_rx_q.pop_front());
        end
        rd(A_RXQ, d);
        chk({tag, " R9 empty read zero"}, d, 32'h0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(A_CTRL, d); chk("R1 ctrl", d, 32'h0);
        rd(A_STAT, d); chk("R1 status", d, 32'h0);
        chk("R1 select lines", 32'(cs_line), 32'hF);
        chk("R1 sclk", 32'(sclk), 32'h0);

        // R3/R5: all four clock modes, each on its own select line
        for (int m = 0; m < 4; m++) begin
            inv = m[0];
            configure(8, m[1], m[0], m[0], 0, m);
            queue_word(32'h0000_00A5 + 32'(m * 37), 1, 1);
            kick();
            wait_done("R3 mode", 1);
            compare_serial("R3 mode");
            drain_rx("R3 mode");
        end

        // R2: 24-bit words with ignored upper bits, 32-bit and 1-bit words
        inv = 1'b0;
        configure(24, 0, 0, 0, 1, 2);
        queue_word(32'h00C3_5A1E, 1, 1);
        queue_word(32'hFF12_3456, 1, 1);
        kick(); wait_done("R2 len24", 2);
        compare_serial("R2 len24"); drain_rx("R2 len24");

        inv = 1'b1;
        configure(32, 1, 1, 1, 0, 3);
        queue_word(32'h8000_0001, 1, 1);
        queue_word(32'h1234_ABCD, 1, 1);
        kick(); wait_done("R2 len32", 2);
        compare_serial("R2 len32"); drain_rx("R2 len32");

        configure(1, 0, 0, 0, 0, 1);
        queue_word(32'hFFFF_FFFE, 1, 1);
        queue_word(32'h0000_0001, 1, 1);
        kick(); wait_done("R2 len1", 2);
        compare_serial("R2 len1"); drain_rx("R2 len1");

        // R4: every divider code
        inv = 1'b0;
        for (int r = 0; r < 8; r++) begin
            configure(8, r[0], r[1], 0, r, 1);
            queue_word(32'h0000_0069 ^ 32'(r), 1, 1);
            kick(); wait_done("R4 rate", 1);
            compare_serial("R4 rate"); drain_rx("R4 rate");
        end

        // R7: fifth write to a full transmit queue is ignored
        configure(8, 0, 0, 0, 0, 0);
        for (int k = 0; k < 4; k++) queue_word(32'h10 + 32'(k), 1, 1);
        queue_word(32'hEE, 0, 0);
        kick(); wait_done("R7 full", 4);
        compare_serial("R7 full"); drain_rx("R7 full");

        // R8: receive overflow drops the word and sets status bit 6
        for (int k = 0; k < 4; k++) queue_word(32'h20 + 32'(k), 1, 1);
        kick(); wait_done("R8 fill", 4);
        queue_word(32'h77, 1, 0);
        kick(); wait_done("R8 drop", 1);
        rd(A_STAT, d); chk("R8 overflow flag", 32'(d[S_OVF]), 32'd1);
        wr(A_STAT, 32'h1 << S_OVF);
        rd(A_STAT, d); chk("R8 overflow cleared", 32'(d[S_OVF]), 32'd0);
        compare_serial("R8"); drain_rx("R8 kept words");

        // R11: exchange with an empty transmit queue
        kick(); wait_done("R11 empty", 0);
        chk("R11 no serial words", got_ser_q.size(), 0);

        // R10: disabling flushes both queues
        queue_word(32'h5A, 1, 0);
        kick(); wait_done("R10 pre", 1);
        compare_serial("R10 pre");
        wr(A_TXQ, 32'h11); wr(A_TXQ, 32'h22);
        wr(A_CTRL, cur_ctrl & ~32'h1);
        wr(A_CTRL, cur_ctrl);
        rd(A_RXQ, d); chk("R10 rx flushed", d, 32'h0);
        kick(); wait_done("R10 tx flushed", 0);

        // R12: word written while the exchange runs, swept around the pop
        for (int off = 0; off < 4; off++) begin
            configure(8, 0, 0, 0, 1, 0);
            queue_word(32'h3C + 32'(off), 1, 1);
            kick();
            repeat (off) @(negedge clk);
            queue_word(32'hC3 - 32'(off), 1, 1);
            wait_done("R12 late word", 2);
            compare_serial("R12"); drain_rx("R12");
        end

        summary();
        $finish;
    end
endmodule